// File: doc/BRIEF.md
# Programmable Multi-Address Bus Matcher

This block decides whether the first byte received after a bus START names this target. The byte's upper seven bits are compared with one fixed device address and with four addresses that software can change: three alias ("sub") addresses and one broadcast ("all-call") address. Each changeable address has its own enable bit. The bus front end presents the byte on a one-cycle strobe. One cycle later the block reports whether to acknowledge, and which address produced the hit.

The address registers and the enable register sit in a small byte-wide register file. Access is through a plain index / write-data / write-strobe / read-data port. The bus engine (START/STOP detection, shifting, ACK drive) lives elsewhere and uses the match flag to decide whether to pull ACK low.

Top module: `addr_alias_matcher`

## Requirements
- R1: After reset, index 02h reads E2h, 03h reads E4h, 04h reads E8h, 05h reads E0h and index 00h reads 08h.
- R2: A write to index 02h..05h stores only data bits 7:1 as the address. Bit 0 of those registers always reads back 0.
- R3: Index 00h is the enable register: bit 0 enables sub 1, bit 1 sub 2, bit 2 sub 3, bit 3 all-call. Bits 7:4 always read 0, whatever was written.
- R4: A strobed byte whose bits 7:1 equal the fixed device address (parameter, default 40h, so bytes 80h/81h) always matches, with index 0.
- R5: A sub address matches only while its enable bit is 1. After reset no sub address matches.
- R6: The all-call address matches only while its enable bit is 1. Clearing it stops all-call matching.
- R7: Bit 0 (read/write direction) of the strobed byte has no effect on the result.
- R8: The match index codes are 0 device, 1 sub 1, 2 sub 2, 3 sub 3, 4 all-call. When several entries hit, the lowest code is reported. The index reads 0 whenever match is low.
- R9: Match and index are registered, valid in the cycle after the strobe, for one cycle only. A register write in the same cycle as a strobe takes effect from the next strobe.
- R10: Indices other than 00h and 02h..05h read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx | input | 8 | Register index for read and write |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rdata | output | 8 | Read data for reg_idx (combinational) |
| addr_valid | input | 1 | Strobe: first byte after START is on addr_byte |
| addr_byte | input | 8 | Received address byte, bit 0 is R/W |
| match | output | 1 | One-cycle acknowledge decision, the cycle after the strobe |
| match_idx | output | 3 | Code of the winning address, 0 when no match |

## Verification
The bench probes sub addresses straight after reset, before they are enabled. A design with wrong enable reset values would acknowledge them there. It writes all-ones into address registers, to catch a design that keeps or compares bit 0. It also toggles the R/W bit on each probe, so a comparator that includes that bit loses half of its matches. It forces overlapping addresses (sub equal to the device address, two subs equal) to expose a wrong priority order. It issues a write in the same cycle as a strobe, which a design that bypasses the new value into the compare would get wrong. Random traffic to unmapped indices would reveal any write decode that aliases into real registers.

// File: rtl/amatch_pkg.sv
package amatch_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 7;
  localparam int NUM_SUB   = 3;
  localparam int NUM_ALIAS = NUM_SUB + 1;   // subs plus all-call
  localparam int NUM_SRC   = NUM_ALIAS + 1; // plus fixed device address
  localparam int SRC_IDX_W = $clog2(NUM_SRC);

  localparam logic [BYTE_W-1:0] CTRL_IDX   = 8'h00;
  localparam logic [BYTE_W-1:0] ALIAS_BASE = 8'h02;

  localparam logic [ADDR_W-1:0] ALIAS_ROOT = 7'h70;

  typedef logic [ADDR_W-1:0] addr7_t;

  // sub k resets to root with one extra bit set; all-call resets to root
  function automatic addr7_t alias_rst(input int k);
    if (k < NUM_SUB) return ALIAS_ROOT | (addr7_t'(1) << k);
    return ALIAS_ROOT;
  endfunction

  localparam logic [NUM_ALIAS-1:0] EN_RST = {1'b1, {NUM_SUB{1'b0}}};
endpackage

// File: rtl/amatch_regfile.sv
module amatch_regfile
  import amatch_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [BYTE_W-1:0]                  reg_idx,
  input  logic [BYTE_W-1:0]                  reg_wdata,
  input  logic                               reg_wr,
  output logic [BYTE_W-1:0]                  reg_rdata,
  output logic [NUM_ALIAS-1:0][ADDR_W-1:0]   alias_addr,
  output logic [NUM_ALIAS-1:0]               alias_en
);

  logic [NUM_ALIAS-1:0][ADDR_W-1:0] addr_q, addr_nxt;
  logic [NUM_ALIAS-1:0]             en_q, en_nxt;
  logic [NUM_ALIAS-1:0]             addr_sel;
  logic                             en_sel;
  logic                             addr_ce, en_ce;

  // index decode
  always_comb begin
    en_sel = (reg_idx == CTRL_IDX);
    for (int k = 0; k < NUM_ALIAS; k++) begin
      addr_sel[k] = (reg_idx == ALIAS_BASE + BYTE_W'(k));
    end
  end

  assign en_ce   = reg_wr & en_sel;
  assign addr_ce = reg_wr & (|addr_sel);

  // next state
  always_comb begin
    en_nxt   = en_q;
    addr_nxt = addr_q;
    if (en_sel) en_nxt = reg_wdata[NUM_ALIAS-1:0];
    for (int k = 0; k < NUM_ALIAS; k++) begin
      if (addr_sel[k]) addr_nxt[k] = reg_wdata[BYTE_W-1:1];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= EN_RST;
    end else if (en_ce) begin
      en_q <= en_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_ALIAS; k++) addr_q[k] <= alias_rst(k);
    end else if (addr_ce) begin
      addr_q <= addr_nxt;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (en_sel) reg_rdata = BYTE_W'(en_q);
    for (int k = 0; k < NUM_ALIAS; k++) begin
      if (addr_sel[k]) reg_rdata = {addr_q[k], 1'b0};
    end
  end

  assign alias_addr = addr_q;
  assign alias_en   = en_q;

endmodule

// File: rtl/amatch_compare.sv
module amatch_compare
  import amatch_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h40
)(
  input  logic [BYTE_W-1:0]                addr_byte,
  input  logic [NUM_ALIAS-1:0][ADDR_W-1:0] alias_addr,
  input  logic [NUM_ALIAS-1:0]             alias_en,
  output logic [NUM_SRC-1:0]               hit
);

  addr7_t rx_addr;
  assign rx_addr = addr_byte[BYTE_W-1:1];

  // slot 0: fixed device address, always enabled
  assign hit[0] = (rx_addr == DEV_ADDR);

  for (genvar g = 0; g < NUM_ALIAS; g++) begin : g_alias
    assign hit[g+1] = alias_en[g] & (rx_addr == alias_addr[g]);
  end

endmodule

// File: rtl/amatch_prio.sv
module amatch_prio #(
  parameter int N     = 5,
  parameter int IDX_W = $clog2(N)
)(
  input  logic [N-1:0]     hit,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  // lowest set bit wins
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) idx = IDX_W'(i);
    end
  end

  assign any = |hit;

endmodule

// File: rtl/addr_alias_matcher.sv
module addr_alias_matcher
  import amatch_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h40
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BYTE_W-1:0]    reg_idx,
  input  logic [BYTE_W-1:0]    reg_wdata,
  input  logic                 reg_wr,
  output logic [BYTE_W-1:0]    reg_rdata,
  input  logic                 addr_valid,
  input  logic [BYTE_W-1:0]    addr_byte,
  output logic                 match,
  output logic [SRC_IDX_W-1:0] match_idx
);

  logic [NUM_ALIAS-1:0][ADDR_W-1:0] alias_addr;
  logic [NUM_ALIAS-1:0]             alias_en;
  logic [NUM_SRC-1:0]               hit;
  logic                             hit_any;
  logic [SRC_IDX_W-1:0]             hit_idx;

  logic                 match_q, match_nxt;
  logic [SRC_IDX_W-1:0] idx_q, idx_nxt;

  amatch_regfile u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_idx    (reg_idx),
    .reg_wdata  (reg_wdata),
    .reg_wr     (reg_wr),
    .reg_rdata  (reg_rdata),
    .alias_addr (alias_addr),
    .alias_en   (alias_en)
  );

  amatch_compare #(.DEV_ADDR(DEV_ADDR)) u_cmp (
    .addr_byte  (addr_byte),
    .alias_addr (alias_addr),
    .alias_en   (alias_en),
    .hit        (hit)
  );

  amatch_prio #(.N(NUM_SRC), .IDX_W(SRC_IDX_W)) u_prio (
    .hit (hit),
    .any (hit_any),
    .idx (hit_idx)
  );

  always_comb begin
    match_nxt = addr_valid & hit_any;
    idx_nxt   = match_nxt ? hit_idx : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      match_q <= match_nxt;
      idx_q   <= idx_nxt;
    end
  end

  assign match     = match_q;
  assign match_idx = idx_q;

endmodule

// File: rtl/amatch_checker.sv
module amatch_checker
  import amatch_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h40
)(
  input logic                 clk,
  input logic                 rst_n,
  input logic [BYTE_W-1:0]    reg_idx,
  input logic [BYTE_W-1:0]    reg_rdata,
  input logic                 addr_valid,
  input logic [BYTE_W-1:0]    addr_byte,
  input logic                 match,
  input logic [SRC_IDX_W-1:0] match_idx
);

  logic idx_alias, idx_ctrl;
  assign idx_ctrl  = (reg_idx == CTRL_IDX);
  assign idx_alias = (reg_idx >= ALIAS_BASE) &&
                     (reg_idx < ALIAS_BASE + BYTE_W'(NUM_ALIAS));

  p_lsb_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_alias |-> (reg_rdata[0] == 1'b0));

  p_en_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_ctrl |-> (reg_rdata[BYTE_W-1:NUM_ALIAS] == '0));

  p_dev_always_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_byte[BYTE_W-1:1] == DEV_ADDR) |=>
      (match && match_idx == '0));

  p_idx_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> (match_idx < SRC_IDX_W'(NUM_SRC)));

  p_idx_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !match |-> (match_idx == '0));

  p_only_after_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |=> !match);

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_ctrl && !idx_alias) |-> (reg_rdata == '0));

endmodule

bind addr_alias_matcher amatch_checker #(.DEV_ADDR(DEV_ADDR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_idx    (reg_idx),
  .reg_rdata  (reg_rdata),
  .addr_valid (addr_valid),
  .addr_byte  (addr_byte),
  .match      (match),
  .match_idx  (match_idx)
);

// File: tb/addr_alias_matcher_bench.sv
`timescale 1ns/1ps
module addr_alias_matcher_bench;
  localparam logic [6:0] DEV = 7'h40;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] reg_idx, reg_wdata, reg_rdata, addr_byte;
  logic       reg_wr, addr_valid, match;
  logic [2:0] match_idx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [6:0] m_addr [4];
  logic [3:0] m_en;

  always #5 clk = ~clk;

  addr_alias_matcher #(.DEV_ADDR(DEV)) u_addr_alias_matcher (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rdata(reg_rdata), .addr_valid(addr_valid),
    .addr_byte(addr_byte), .match(match), .match_idx(match_idx)
  );

  function automatic void m_reset();
    m_addr[0] = 7'h71; m_addr[1] = 7'h72; m_addr[2] = 7'h74; m_addr[3] = 7'h70;
    m_en = 4'b1000;
  endfunction

  function automatic logic [7:0] m_read(logic [7:0] i);
    if (i == 8'h00) return {4'b0, m_en};
    if (i >= 8'h02 && i <= 8'h05) return {m_addr[i-2], 1'b0};
    return 8'h00;
  endfunction

  function automatic void m_write(logic [7:0] i, logic [7:0] d);
    if (i == 8'h00) m_en = d[3:0];
    else if (i >= 8'h02 && i <= 8'h05) m_addr[i-2] = d[7:1];
  endfunction

  function automatic logic [3:0] exp_res(logic [7:0] b);
    if (b[7:1] == DEV) return 4'b1000;
    for (int k = 0; k < 4; k++)
      if (m_en[k] && m_addr[k] == b[7:1]) return {1'b1, 3'(k + 1)};
    return 4'b0000;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] i, logic [7:0] d);
    @(negedge clk); reg_idx = i; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    m_write(i, d);
  endtask

  task automatic rd(logic [7:0] i, string req);
    @(negedge clk); reg_idx = i;
    #1 chk(req, 32'(reg_rdata), 32'(m_read(i)));
  endtask

  task automatic probe(logic [7:0] b, string req);
    logic [3:0] e;
    @(negedge clk); addr_valid = 1'b1; addr_byte = b; e = exp_res(b);
    @(negedge clk); addr_valid = 1'b0;
    chk(req, {28'b0, match, match_idx}, {28'b0, e});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    reg_idx = 0; reg_wdata = 0; reg_wr = 0; addr_valid = 0; addr_byte = 0;
    rst_n = 1'b0;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    chk("R9 idle after reset", {31'b0, match}, 0);
    for (int i = 0; i < 6; i++) rd(8'(i), "R1 reset readback");

    // R5 subs not acknowledged after reset; R6 all-call is; R7 rw bit
    probe(8'hE2, "R5 sub1 disabled after reset");
    probe(8'hE9, "R5 sub3 disabled after reset");
    probe(8'hE0, "R6 all-call write");
    probe(8'hE1, "R7 all-call read");
    probe(8'h80, "R4 device write");
    probe(8'h81, "R7 R4 device read");
    @(negedge clk);
    chk("R9 single-cycle pulse", {31'b0, match}, 0);

    // R2 bit 0 dropped
    wr(8'h02, 8'hFF);
    rd(8'h02, "R2 lsb reads zero");
    probe(8'hFE, "R2 not enabled yet");
    // R3 enables, upper bits ignored
    wr(8'h00, 8'hFF);
    rd(8'h00, "R3 upper enable bits zero");
    probe(8'hFF, "R5 sub1 enabled read");
    probe(8'hE4, "R5 sub2 enabled");
    probe(8'hE8, "R5 sub3 enabled");

    // R8 priority
    wr(8'h03, 8'h80);
    probe(8'h80, "R8 device beats sub2");
    wr(8'h04, 8'hFE);
    probe(8'hFE, "R8 sub1 beats sub3");
    wr(8'h02, 8'h20);
    probe(8'hFF, "R8 sub3 after sub1 moved");
    wr(8'h04, 8'hE0);
    probe(8'hE0, "R8 sub3 beats all-call");

    // R6 disable all-call
    wr(8'h04, 8'h10);
    wr(8'h00, 8'h07);
    probe(8'hE0, "R6 all-call disabled");
    wr(8'h00, 8'h08);
    probe(8'h21, "R5 sub1 disabled again");

    // R10 unmapped
    wr(8'h01, 8'hAA);
    wr(8'h06, 8'h55);
    wr(8'hFF, 8'h33);
    rd(8'h01, "R10 unmapped reads zero");
    rd(8'h06, "R10 unmapped reads zero");
    for (int i = 0; i < 6; i++) rd(8'(i), "R10 no alias into real registers");

    // R9 same-cycle write vs strobe
    begin
      logic [3:0] e;
      @(negedge clk);
      reg_idx = 8'h05; reg_wdata = 8'h44; reg_wr = 1'b1;
      addr_valid = 1'b1; addr_byte = 8'hE0; e = exp_res(8'hE0);
      @(negedge clk); reg_wr = 1'b0; addr_valid = 1'b0; m_write(8'h05, 8'h44);
      chk("R9 same-cycle write uses old value", {28'b0, match, match_idx}, {28'b0, e});
      probe(8'h45, "R9 new value on next strobe");
    end

    // random traffic
    for (int n = 0; n < 600; n++) begin
      int sel = $urandom_range(0, 9);
      if (sel < 3) begin
        logic [7:0] i = (sel == 0) ? 8'($urandom_range(0, 7)) : 8'($urandom);
        wr(i, 8'($urandom));
      end else if (sel < 5) begin
        rd(8'($urandom_range(0, 8)), "R1 R2 R3 R10 random read");
      end else begin
        int pick = $urandom_range(0, 5);
        logic [7:0] b;
        if (pick == 5) b = 8'($urandom);
        else if (pick == 4) b = {DEV, 1'b0};
        else b = {m_addr[pick], 1'b0};
        b[0] = 1'($urandom);
        probe(b, "R4 R5 R6 R7 R8 random probe");
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule